// File: doc/BRIEF.md
# Shared strap and suspend-indicator pin controller

This block owns a single bidirectional pad that plays two roles over its life. Straight after reset the pad is left undriven so that an external pull resistor can set it. Early on, the block reads it several times and turns it into a power-switching mode: grouped ports (gang) or per-port (individual). That mode is then frozen. Much later, the block turns the pad into an output that signals whether the chip is running normally or in global suspend.

The level driven for each state depends on the strapped mode. With a gang strap the pad is low while running and high in suspend. With an individual strap the levels are inverted, so the pad is high while running and low in suspend. The suspend request comes from another clock domain and is resynchronised before it reaches the pad. All windows are counted in clock cycles. At 12 MHz, the default sample point is 240 cycles (20 µs) and the output switch is 600000 cycles (50 ms).

Top module: `strap_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first latch, `pin_oe_o`, `pin_o` and `gang_mode_o` are all 0.
- R2: While `pin_oe_o` is 0, `pin_o` is 0.
- R3: `pin_i` is sampled only on clock edges SAMPLE_CYC-VOTES+1 through SAMPLE_CYC after reset release. Edge 1 is the first rising edge with `rst_ni` high. The pin level on every other edge has no effect on `gang_mode_o`.
- R4: On edge SAMPLE_CYC+1, `gang_mode_o` takes the majority of the VOTES samples, where VOTES is odd: 1 (gang) if more than half the samples were 1, else 0 (individual).
- R5: Once latched, `gang_mode_o` does not change until the next reset, whatever `pin_i` does.
- R6: `pin_oe_o` is 0 up to and including edge SWITCH_CYC-1. It becomes 1 on edge SWITCH_CYC and then stays 1 until reset.
- R7: With `gang_mode_o`=1 and the pad in output mode, `pin_o` is 0 when the synchronised suspend is 0 and 1 when it is 1.
- R8: With `gang_mode_o`=0 and the pad in output mode, `pin_o` is 1 when the synchronised suspend is 0 and 0 when it is 1.
- R9: `suspend_i` passes through two flops. A change driven between edges n and n+1 shows at `pin_o` after edge n+2, and not after edge n+1.
- R10: `suspend_i` has no effect on `pin_o` or `pin_oe_o` during the input phase.
- R11: Asserting `rst_ni` in the output phase at once sets `pin_oe_o`, `pin_o` and `gang_mode_o` to 0. The next release runs a fresh strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Level seen at the pad |
| suspend_i | input | 1 | Global suspend request, asynchronous |
| pin_oe_o | output | 1 | Pad output enable, 1 = driven |
| pin_o | output | 1 | Level driven onto the pad |
| gang_mode_o | output | 1 | Latched mode, 1 = gang, 0 = individual |

## Verification
Some properties are checked on every cycle by the assertions:
- the pad is never driven high while its output enable is low;
- the output phase never begins before a mode is latched, and never ends without a reset;
- the latched mode never moves once taken;
- a rise at the synchroniser output always follows a high suspend input two edges earlier.

The other behaviours can only be shown by the bench's scenarios. These are the exact edges of the sample window and the output switch, the majority result when one or two samples disagree, both polarity mappings, the two-edge suspend latency, and a reset in mid-run that is followed by a different strap.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic {
    MODE_INDIV = 1'b0,
    MODE_GANG  = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/strap_seq_timer.sv
module strap_seq_timer #(
  parameter int SAMPLE_CYC = 240,
  parameter int VOTES      = 5,
  parameter int SWITCH_CYC = 600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_o,
  output logic latch_o,
  output logic out_phase_o
);
  localparam int CW = $clog2(SWITCH_CYC + 1);
  localparam logic [CW-1:0] WIN_LO   = CW'(SAMPLE_CYC - VOTES);
  localparam logic [CW-1:0] WIN_HI   = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] LATCH_AT = CW'(SAMPLE_CYC);
  localparam logic [CW-1:0] OUT_AT   = CW'(SWITCH_CYC - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(SWITCH_CYC);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == OUT_AT)  out_q <= 1'b1;
    end
  end

  assign sample_o    = (cnt_q >= WIN_LO) && (cnt_q <= WIN_HI);
  assign latch_o     = (cnt_q == LATCH_AT);
  assign out_phase_o = out_q;

  // R6
  out_phase_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |=> out_q);

  // R6
  latch_before_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !out_q);
endmodule

// File: rtl/strap_voter.sv
module strap_voter #(
  parameter int VOTES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sample_i,
  input  logic latch_i,
  output logic mode_o,
  output logic valid_o
);
  localparam int OW = $clog2(VOTES + 1);

  logic [VOTES-1:0] samp_q;
  logic [OW-1:0]    ones;
  logic             mode_q, vld_q, maj;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTES; i++) ones = ones + OW'(samp_q[i]);
  end

  assign maj = (int'(ones) * 2) > VOTES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      mode_q <= strap_pkg::MODE_INDIV;
      vld_q  <= 1'b0;
    end else begin
      if (sample_i) samp_q <= {samp_q[VOTES-2:0], pin_i};
      if (latch_i && !vld_q) begin
        mode_q <= maj;
        vld_q  <= 1'b1;
      end
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = vld_q;

  // R5
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> (vld_q && $stable(mode_q)));
endmodule

// File: rtl/strap_sync2.sv
module strap_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];

  // R9
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(d_i, STAGES));
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl #(
  parameter int SAMPLE_CYC = 240,
  parameter int VOTES      = 5,
  parameter int SWITCH_CYC = 600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic suspend_i,
  output logic pin_oe_o,
  output logic pin_o,
  output logic gang_mode_o
);
  logic sample, latch, out_phase, mode, mode_vld, susp_s;

  strap_seq_timer #(.SAMPLE_CYC(SAMPLE_CYC), .VOTES(VOTES), .SWITCH_CYC(SWITCH_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_o(sample), .latch_o(latch), .out_phase_o(out_phase)
  );

  strap_voter #(.VOTES(VOTES)) u_voter (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .sample_i(sample), .latch_i(latch),
    .mode_o(mode), .valid_o(mode_vld)
  );

  strap_sync2 #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(suspend_i), .q_o(susp_s)
  );

  // gang: high in suspend; individual: low in suspend
  always_comb begin
    if (!out_phase)                       pin_o = 1'b0;
    else if (mode == strap_pkg::MODE_GANG) pin_o = susp_s;
    else                                  pin_o = ~susp_s;
  end

  assign pin_oe_o    = out_phase;
  assign gang_mode_o = mode;

  // R2
  undriven_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);

  // R6
  out_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> mode_vld);
endmodule

// File: tb/strap_pin_ctrl_tb.sv
module strap_pin_ctrl_tb;
  localparam int S = 20;
  localparam int V = 3;
  localparam int W = 60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pin_i = 1'b0;
  logic suspend_i = 1'b0;
  logic pin_oe_o, pin_o, gang_mode_o;

  int n_chk = 0;
  int n_fail = 0;
  int edge_cnt = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    logic  oe;
    logic  pin;
    logic  mode;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  strap_pin_ctrl #(.SAMPLE_CYC(S), .VOTES(V), .SWITCH_CYC(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_i), .suspend_i(suspend_i),
    .pin_oe_o(pin_oe_o), .pin_o(pin_o), .gang_mode_o(gang_mode_o)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) edge_cnt <= 0;
    else         edge_cnt <= edge_cnt + 1;

  task automatic check(string req, logic oe, logic pin, logic mode);
    n_chk++;
    if (pin_oe_o !== oe || pin_o !== pin || gang_mode_o !== mode) begin
      n_fail++;
      $display("FAIL %s @cyc %0d: oe/pin/mode got %b%b%b exp %b%b%b",
               req, edge_cnt, pin_oe_o, pin_o, gang_mode_o, oe, pin, mode);
    end
  endtask

  task automatic push(int cyc, logic oe, logic pin, logic mode, string req);
    exp_t e;
    e.cyc = cyc; e.oe = oe; e.pin = pin; e.mode = mode; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (rst_ni && sb_q.size() != 0 && sb_q[0].cyc == edge_cnt) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, e.oe, e.pin, e.mode);
    end
  end

  task automatic wait_cyc(int n);
    while (edge_cnt != n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic start(logic p);
    rst_ni = 1'b0;
    pin_i = p;
    suspend_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    // in reset
    @(negedge clk);
    pin_i = 1'b1;
    @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0, 1'b0);

    // gang, steady strap high
    start(1'b1);
    push(1,  0, 0, 0, "R1 after release");
    push(S,  0, 0, 0, "R4 not yet latched");
    push(S+1,0, 0, 1, "R4 gang latched");
    push(W-1,0, 0, 1, "R6 still input");
    push(W,  1, 0, 1, "R6 output on, R7 gang normal");
    push(70, 1, 0, 1, "R5 mode held after pin change");
    push(71, 1, 0, 1, "R9 one edge no change");
    push(72, 1, 1, 1, "R7 gang suspend high");
    push(77, 1, 0, 1, "R7 gang resume low");
    wait_cyc(30); pin_i = 1'b0;
    wait_cyc(70); suspend_i = 1'b1;
    wait_cyc(75); suspend_i = 1'b0;
    drain();

    // individual, single 1 among the samples
    start(1'b0);
    push(10, 0, 0, 0, "R10 suspend ignored in input phase");
    push(S+1,0, 0, 0, "R4 majority low");
    push(W,  1, 1, 0, "R8 indiv normal high");
    push(63, 1, 1, 0, "R9 one edge no change");
    push(64, 1, 0, 0, "R8 indiv suspend low");
    push(68, 1, 1, 0, "R8 indiv resume high");
    wait_cyc(5);  suspend_i = 1'b1;
    wait_cyc(10); suspend_i = 1'b0;
    wait_cyc(18); pin_i = 1'b1;
    wait_cyc(19); pin_i = 1'b0;
    wait_cyc(62); suspend_i = 1'b1;
    wait_cyc(66); suspend_i = 1'b0;
    drain();

    // gang, pin low outside window, one 0 inside
    start(1'b0);
    push(S+1,0, 0, 1, "R3 outside window ignored, R4 majority high");
    wait_cyc(16); pin_i = 1'b1;
    wait_cyc(19); pin_i = 1'b0;
    wait_cyc(20); pin_i = 1'b0;
    drain();

    // two 0 among three -> individual, then reset mid-run
    start(1'b1);
    push(S+1,0, 0, 0, "R4 two low of three");
    push(65, 1, 1, 0, "R8 before mid reset");
    wait_cyc(17); pin_i = 1'b0;
    wait_cyc(19); pin_i = 1'b1;
    drain();
    #1 rst_ni = 1'b0;
    #1 check("R11 async reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    push(S+1,0, 0, 1, "R11 fresh strap gang");
    push(W,  1, 0, 1, "R11 output again");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule